// File: doc/BRIEF.md
# Four-Channel Host Mailbox Register Block

This block sits on the management-processor side of a host link. It provides four byte-oriented mailbox channels in the keyboard-controller style. Each channel has an inbound data word written by the host, an outbound data word written by the management processor, and a status word. Two handshake flags live in the status word: "outbound full" and "inbound full". Both sides set and clear these flags as a side effect of their ordinary reads and writes.

The management processor reaches every register over a simple word-indexed bus. The control words that switch channels on and arm their inbound interrupts sit on the same bus. The host side is a single access port that selects a channel and then either the data word or the status word. A host write to the data word can be tagged as a command.

Every channel keeps a pending-interrupt bit, which drives its own interrupt line. A shared line is the OR of all four pending bits.

Top module: `kcs_mailbox`

## Requirements
- R1: After reset, every register reads zero, all four channel interrupt lines are low and the shared line is low.
- R2: The control words at byte offsets 0x00, 0x08, 0x10 and 0x100 store any 32-bit value written by the management side and return it on read.
- R3: The management side finds the channel registers at these byte offsets. For channels 0 to 2, inbound data is at 0x24/0x28/0x2C, outbound data at 0x30/0x34/0x38, and status at 0x3C/0x40/0x44. For channel 3, inbound data is at 0x114, outbound data at 0x118 and status at 0x11C. The word index on the bus is the byte offset divided by four.
- R4: A management write to a channel's outbound data word stores the value and sets status bit 0 (outbound full).
- R5: A host read of a channel's data word returns the outbound value and clears status bit 0.
- R6: A host write to a channel's data word stores the value in the inbound word and sets status bit 1 (inbound full). The same write sets status bit 3 when the command select is high and clears it when the select is low.
- R7: A management read of an inbound data word returns its value and clears status bit 1.
- R8: A host data write raises a channel's pending bit only when that channel is enabled and its inbound interrupt is armed. The enable bits are: channel 0 at bit 5 of 0x00, channel 1 at bit 6 of 0x00, channel 2 at bit 7 of 0x00 together with bit 2 of 0x10, and channel 3 at bit 0 of 0x100. The arm bits are bits 1, 2 and 3 of 0x08 for channels 0 to 2, and bit 1 of 0x100 for channel 3.
- R9: A pending bit stays set until a management read of that channel's inbound word finds inbound-full set. Clearing the enable or arm bits does not drop it.
- R10: The shared interrupt is high exactly when at least one channel interrupt line is high.
- R11: A host write to a status word leaves the stored status unchanged.
- R12: Management reads of any other offset return zero, and management writes there change no register.
- R13: When a flag is set and cleared in the same cycle, the set wins. Examples are an outbound write meeting a host outbound read, or a host inbound write meeting a management inbound read.
- R14: A management write to a status word stores the written value, and the host sees it when it reads that status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_valid | input | 1 | Management access strobe |
| mgmt_write | input | 1 | 1 = write, 0 = read |
| mgmt_widx | input | IDX_W (10) | Word index (byte offset divided by four) |
| mgmt_wdata | input | DATA_W (32) | Management write data |
| mgmt_rdata | output | DATA_W (32) | Management read data, valid in the access cycle |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_chan | input | 2 | Channel selected by the host |
| host_sts_sel | input | 1 | 1 = status word, 0 = data word |
| host_cmd | input | 1 | Command select for host data writes |
| host_wdata | input | DATA_W (32) | Host write data |
| host_rdata | output | DATA_W (32) | Host read data: outbound word or status word |
| irq_chan | output | 4 | Per-channel interrupt lines (pending bits) |
| irq_any | output | 1 | OR of all channel interrupt lines |

## Verification
The assertions assume that every input holds a known value from reset onward. They also assume that qualifiers such as direction, channel and select count only while the matching valid is high. The status-hold and outbound-clear properties are written for cycles with no management access to the same channel. Same-cycle collisions from the two sides are covered by R13 and are left out of those properties. The bench drives every input from time zero and returns both strobes low between operations. It creates collisions only in one dedicated step and checks them at the ports.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);

    // status bit positions (host software decodes these)
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CD  = 3;

    // control word byte offsets
    localparam int OFS_ENA  = 'h000;
    localparam int OFS_ARM  = 'h008;
    localparam int OFS_EXT  = 'h010;
    localparam int OFS_CH3C = 'h100;

    function automatic int idr_ofs(int ch);
        return (ch < 3) ? ('h24 + 4 * ch) : 'h114;
    endfunction

    function automatic int odr_ofs(int ch);
        return (ch < 3) ? ('h30 + 4 * ch) : 'h118;
    endfunction

    function automatic int sts_ofs(int ch);
        return (ch < 3) ? ('h3C + 4 * ch) : 'h11C;
    endfunction
endpackage

// File: rtl/kcs_ctrl_regs.sv
module kcs_ctrl_regs
    import kcs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              hit,
    output logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] ibf_arm
);
    typedef struct packed {
        logic [DATA_W-1:0] ena;
        logic [DATA_W-1:0] arm;
        logic [DATA_W-1:0] ext;
        logic [DATA_W-1:0] ch3c;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic sel_ena, sel_arm, sel_ext, sel_ch3c;

    assign sel_ena  = (widx == IDX_W'(OFS_ENA  >> 2));
    assign sel_arm  = (widx == IDX_W'(OFS_ARM  >> 2));
    assign sel_ext  = (widx == IDX_W'(OFS_EXT  >> 2));
    assign sel_ch3c = (widx == IDX_W'(OFS_CH3C >> 2));

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            if (sel_ena)  ctl_d.ena  = wdata;
            if (sel_arm)  ctl_d.arm  = wdata;
            if (sel_ext)  ctl_d.ext  = wdata;
            if (sel_ch3c) ctl_d.ch3c = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        hit   = sel_ena | sel_arm | sel_ext | sel_ch3c;
        rdata = '0;
        if (sel_ena)  rdata = ctl_q.ena;
        if (sel_arm)  rdata = ctl_q.arm;
        if (sel_ext)  rdata = ctl_q.ext;
        if (sel_ch3c) rdata = ctl_q.ch3c;
    end

    // per-channel enable and inbound interrupt arm decode
    assign chan_en = {ctl_q.ch3c[0], ctl_q.ena[7] & ctl_q.ext[2], ctl_q.ena[6], ctl_q.ena[5]};
    assign ibf_arm = {ctl_q.ch3c[1], ctl_q.arm[3], ctl_q.arm[2], ctl_q.arm[1]};

    // R2: a written control word is visible on the next cycle
    assert_ctl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ena) |=> (ctl_q.ena == $past(wdata)));
endmodule

// File: rtl/kcs_channel.sv
module kcs_channel
    import kcs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_rd_idr,
    input  logic              m_wr_idr,
    input  logic              m_wr_odr,
    input  logic              m_wr_sts,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic              h_wr_data,
    input  logic              h_rd_data,
    input  logic              h_wr_sts,
    input  logic              h_cmd,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              irq_ok,
    output logic [DATA_W-1:0] idr,
    output logic [DATA_W-1:0] odr,
    output logic [DATA_W-1:0] sts,
    output logic              pend
);
    typedef struct packed {
        logic [DATA_W-1:0] idr;
        logic [DATA_W-1:0] odr;
        logic [DATA_W-1:0] sts;
        logic              pend;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        // plain stores from the management side
        if (m_wr_idr) ch_d.idr = m_wdata;
        if (m_wr_odr) ch_d.odr = m_wdata;
        if (m_wr_sts) ch_d.sts = m_wdata;
        // clearing side effects
        if (m_rd_idr) begin
            ch_d.sts[ST_IBF] = 1'b0;
            if (ch_q.sts[ST_IBF]) ch_d.pend = 1'b0;
        end
        if (h_rd_data) ch_d.sts[ST_OBF] = 1'b0;
        // setting side effects win over clears
        if (m_wr_odr) ch_d.sts[ST_OBF] = 1'b1;
        if (h_wr_data) begin
            ch_d.idr         = h_wdata;
            ch_d.sts[ST_IBF] = 1'b1;
            ch_d.sts[ST_CD]  = h_cmd;
            if (irq_ok) ch_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign idr  = ch_q.idr;
    assign odr  = ch_q.odr;
    assign sts  = ch_q.sts;
    assign pend = ch_q.pend;

    assert_ibf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr_data |=> (sts[ST_IBF] && sts[ST_CD] == $past(h_cmd) && idr == $past(h_wdata)));

    assert_obf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_data && !m_wr_odr && !m_wr_sts) |=> !sts[ST_OBF]);

    assert_sts_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_sts && !m_rd_idr && !m_wr_odr && !m_wr_sts) |=> $stable(sts));

    assert_pend_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(m_rd_idr));

    assert_pend_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(h_wr_data && irq_ok));
endmodule

// File: rtl/kcs_mailbox.sv
module kcs_mailbox
    import kcs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_valid,
    input  logic              mgmt_write,
    input  logic [IDX_W-1:0]  mgmt_widx,
    input  logic [DATA_W-1:0] mgmt_wdata,
    output logic [DATA_W-1:0] mgmt_rdata,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [CH_W-1:0]   host_chan,
    input  logic              host_sts_sel,
    input  logic              host_cmd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [NUM_CH-1:0] irq_chan,
    output logic              irq_any
);
    logic              m_wr, m_rd;
    logic [DATA_W-1:0] ctl_rdata;
    logic              ctl_hit;
    logic [NUM_CH-1:0] chan_en, ibf_arm;

    logic [NUM_CH-1:0] hit_idr, hit_odr, hit_sts;
    logic [DATA_W-1:0] ch_idr [NUM_CH];
    logic [DATA_W-1:0] ch_odr [NUM_CH];
    logic [DATA_W-1:0] ch_sts [NUM_CH];

    assign m_wr = mgmt_valid & mgmt_write;
    assign m_rd = mgmt_valid & ~mgmt_write;

    kcs_ctrl_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (m_wr),
        .widx    (mgmt_widx),
        .wdata   (mgmt_wdata),
        .rdata   (ctl_rdata),
        .hit     (ctl_hit),
        .chan_en (chan_en),
        .ibf_arm (ibf_arm)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic h_sel;
        assign hit_idr[i] = (mgmt_widx == IDX_W'(idr_ofs(i) >> 2));
        assign hit_odr[i] = (mgmt_widx == IDX_W'(odr_ofs(i) >> 2));
        assign hit_sts[i] = (mgmt_widx == IDX_W'(sts_ofs(i) >> 2));
        assign h_sel      = host_valid && (host_chan == CH_W'(i));

        kcs_channel #(.DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .m_rd_idr  (m_rd & hit_idr[i]),
            .m_wr_idr  (m_wr & hit_idr[i]),
            .m_wr_odr  (m_wr & hit_odr[i]),
            .m_wr_sts  (m_wr & hit_sts[i]),
            .m_wdata   (mgmt_wdata),
            .h_wr_data (h_sel & host_write & ~host_sts_sel),
            .h_rd_data (h_sel & ~host_write & ~host_sts_sel),
            .h_wr_sts  (h_sel & host_write & host_sts_sel),
            .h_cmd     (host_cmd),
            .h_wdata   (host_wdata),
            .irq_ok    (chan_en[i] & ibf_arm[i]),
            .idr       (ch_idr[i]),
            .odr       (ch_odr[i]),
            .sts       (ch_sts[i]),
            .pend      (irq_chan[i])
        );

        assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_chan[i]) |-> $past(host_valid && host_write && !host_sts_sel
                                         && host_chan == CH_W'(i)));
    end

    always_comb begin
        mgmt_rdata = '0;
        if (m_rd) begin
            if (ctl_hit) mgmt_rdata = ctl_rdata;
            for (int i = 0; i < NUM_CH; i++) begin
                if (hit_idr[i]) mgmt_rdata = ch_idr[i];
                if (hit_odr[i]) mgmt_rdata = ch_odr[i];
                if (hit_sts[i]) mgmt_rdata = ch_sts[i];
            end
        end
    end

    assign host_rdata = host_sts_sel ? ch_sts[host_chan] : ch_odr[host_chan];
    assign irq_any    = |irq_chan;

    assert_any_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_chan == '0) |-> !irq_any);
endmodule

// File: tb/kcs_mailbox_tb.sv
module kcs_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_valid = 1'b0, mgmt_write = 1'b0;
    logic [9:0]  mgmt_widx = '0;
    logic [31:0] mgmt_wdata = '0, mgmt_rdata;
    logic        host_valid = 1'b0, host_write = 1'b0, host_sts_sel = 1'b0, host_cmd = 1'b0;
    logic [1:0]  host_chan = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic [3:0]  irq_chan;
    logic        irq_any;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    kcs_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .mgmt_valid(mgmt_valid), .mgmt_write(mgmt_write), .mgmt_widx(mgmt_widx),
        .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
        .host_valid(host_valid), .host_write(host_write), .host_chan(host_chan),
        .host_sts_sel(host_sts_sel), .host_cmd(host_cmd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_chan(irq_chan), .irq_any(irq_any)
    );

    function automatic int o_idr(int c); return (c < 3) ? 'h24 + 4 * c : 'h114; endfunction
    function automatic int o_odr(int c); return (c < 3) ? 'h30 + 4 * c : 'h118; endfunction
    function automatic int o_sts(int c); return (c < 3) ? 'h3C + 4 * c : 'h11C; endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mwr(input int ofs, input logic [31:0] d);
        @(negedge clk);
        mgmt_valid = 1'b1; mgmt_write = 1'b1; mgmt_widx = 10'(ofs >> 2); mgmt_wdata = d;
        @(negedge clk);
        mgmt_valid = 1'b0; mgmt_write = 1'b0;
    endtask

    task automatic mrd(input int ofs, output logic [31:0] d);
        @(negedge clk);
        mgmt_valid = 1'b1; mgmt_write = 1'b0; mgmt_widx = 10'(ofs >> 2);
        #1 d = mgmt_rdata;
        @(negedge clk);
        mgmt_valid = 1'b0;
    endtask

    task automatic hwr(input int c, input logic s, input logic cmd, input logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_chan = 2'(c);
        host_sts_sel = s; host_cmd = cmd; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic hrd(input int c, input logic s, output logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_chan = 2'(c); host_sts_sel = s;
        #1 d = host_rdata;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic set_ctl(input logic [31:0] ena, input logic [31:0] arm,
                           input logic [31:0] ext, input logic [31:0] c3);
        mwr('h000, ena); mwr('h008, arm); mwr('h010, ext); mwr('h100, c3);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all R) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int ctl_ofs [4];
        int bad_ofs [8];
        ctl_ofs = '{'h000, 'h008, 'h010, 'h100};
        bad_ofs = '{'h004, 'h00C, 'h014, 'h020, 'h048, 'h080, 'h104, 'h120};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 irq_chan", 32'(irq_chan), 0);
        check("R1 irq_any", 32'(irq_any), 0);
        for (int k = 0; k < 4; k++) begin mrd(ctl_ofs[k], v); check("R1 ctl", v, 0); end
        for (int c = 0; c < 4; c++) begin
            mrd(o_idr(c), v); check("R1 idr", v, 0);
            mrd(o_odr(c), v); check("R1 odr", v, 0);
            mrd(o_sts(c), v); check("R1 sts", v, 0);
        end

        // R2: control words store and read back
        for (int k = 0; k < 4; k++) begin
            mwr(ctl_ofs[k], 32'hA55A_0000 ^ 32'(ctl_ofs[k] * 3 + 1));
        end
        for (int k = 0; k < 4; k++) begin
            mrd(ctl_ofs[k], v);
            check("R2 ctl readback", v, 32'hA55A_0000 ^ 32'(ctl_ofs[k] * 3 + 1));
        end
        set_ctl(0, 0, 0, 0);

        // R3 R4 R5: outbound path per channel
        for (int c = 0; c < 4; c++) begin
            mwr(o_odr(c), 32'h0000_1000 + 32'(c * 17));
            mrd(o_sts(c), v); check("R4 obf set (mgmt view)", v, 32'h1);
            hrd(c, 1'b1, v); check("R4 obf set (host view)", v, 32'h1);
            mrd(o_odr(c), v); check("R3 odr map", v, 32'h0000_1000 + 32'(c * 17));
            hrd(c, 1'b0, v); check("R5 host odr value", v, 32'h0000_1000 + 32'(c * 17));
            hrd(c, 1'b1, v); check("R5 obf cleared", v, 32'h0);
        end

        // R6 R7: inbound path per channel, data and command
        for (int c = 0; c < 4; c++) begin
            for (int cmd = 0; cmd < 2; cmd++) begin
                hwr(c, 1'b0, 1'(cmd), 32'hC0DE_0000 + 32'(c * 16 + cmd));
                mrd(o_sts(c), v); check("R6 ibf/cd", v, 32'h2 | (32'(cmd) << 3));
                check("R8 no irq while disabled", 32'(irq_chan), 0);
                mrd(o_idr(c), v); check("R7 idr value", v, 32'hC0DE_0000 + 32'(c * 16 + cmd));
                mrd(o_sts(c), v); check("R7 ibf cleared", v, 32'(cmd) << 3);
            end
            mwr(o_sts(c), 32'h0000_005A);
            hrd(c, 1'b1, v); check("R14 mgmt status write", v, 32'h0000_005A);
            mwr(o_sts(c), 32'h0);
        end

        // R8 R9 R10: interrupt gating sweep
        for (int c = 0; c < 4; c++) begin
            for (int cb = 0; cb < 8; cb++) begin
                logic en, ie, x, exp;
                logic [31:0] ena, arm, ext, c3;
                en = cb[0]; ie = cb[1]; x = cb[2];
                ena = '0; arm = '0; ext = {29'b0, x, 2'b0}; c3 = '0;
                case (c)
                    0: begin ena[5] = en; arm[1] = ie; end
                    1: begin ena[6] = en; arm[2] = ie; end
                    2: begin ena[7] = en; arm[3] = ie; end
                    default: begin c3[0] = en; c3[1] = ie; end
                endcase
                exp = en & ie & ((c == 2) ? x : 1'b1);
                set_ctl(ena, arm, ext, c3);
                hwr(c, 1'b0, 1'b0, 32'(cb));
                check("R8 irq_chan gating", 32'(irq_chan), 32'(exp) << c);
                check("R10 irq_any", 32'(irq_any), 32'(exp));
                set_ctl(0, 0, 0, 0);
                check("R9 pending held after disable", 32'(irq_chan), 32'(exp) << c);
                mrd(o_idr(c), v);
                check("R9 pending cleared by idr read", 32'(irq_chan), 0);
                check("R10 irq_any low", 32'(irq_any), 0);
            end
        end

        // R10: two channels pending at once
        set_ctl(32'hE0, 32'h0E, 32'h4, 32'h3);
        hwr(0, 1'b0, 1'b0, 32'h11);
        hwr(3, 1'b0, 1'b1, 32'h33);
        check("R10 two pending", 32'(irq_chan), 32'b1001);
        mrd(o_idr(0), v);
        check("R10 one left", 32'(irq_chan), 32'b1000);
        check("R10 any still high", 32'(irq_any), 1);
        mrd(o_idr(3), v);
        check("R10 none left", 32'(irq_any), 0);
        set_ctl(0, 0, 0, 0);

        // R11: host status write ignored
        for (int c = 0; c < 4; c++) begin
            hwr(c, 1'b0, 1'b1, 32'h77);
            hwr(c, 1'b1, 1'b0, 32'hFFFF_FFFF);
            mrd(o_sts(c), v); check("R11 status unchanged", v, 32'hA);
            mrd(o_idr(c), v); check("R11 idr intact", v, 32'h77);
            mwr(o_sts(c), 32'h0);
        end

        // R12: unmapped offsets
        for (int k = 0; k < 8; k++) begin
            mwr(bad_ofs[k], 32'hFFFF_FFFF);
            mrd(bad_ofs[k], v); check("R12 unmapped reads zero", v, 0);
        end
        mrd('h000, v); check("R12 ctl untouched", v, 0);
        mrd(o_sts(1), v); check("R12 sts untouched", v, 0);
        check("R12 no irq", 32'(irq_chan), 0);

        // R13: same-cycle collisions, set wins
        @(negedge clk);
        mgmt_valid = 1'b1; mgmt_write = 1'b1; mgmt_widx = 10'(o_odr(1) >> 2); mgmt_wdata = 32'hBEEF;
        host_valid = 1'b1; host_write = 1'b0; host_chan = 2'd1; host_sts_sel = 1'b0;
        @(negedge clk);
        mgmt_valid = 1'b0; mgmt_write = 1'b0; host_valid = 1'b0;
        hrd(1, 1'b1, v); check("R13 obf set wins", v, 32'h1);
        @(negedge clk);
        mgmt_valid = 1'b1; mgmt_write = 1'b0; mgmt_widx = 10'(o_idr(2) >> 2);
        host_valid = 1'b1; host_write = 1'b1; host_chan = 2'd2; host_sts_sel = 1'b0;
        host_cmd = 1'b0; host_wdata = 32'h5150;
        @(negedge clk);
        mgmt_valid = 1'b0; host_valid = 1'b0; host_write = 1'b0;
        mrd(o_sts(2), v); check("R13 ibf set wins", v, 32'h2);

        done = 1;
        summary();
        $finish;
    end
endmodule